// File: doc/BRIEF.md
# Ring Interrupt Status Controller

This block holds the interrupt registers for one host-controller DMA ring. The ring engine sends it single-cycle event pulses on a 32-bit vector. Seven positions on that vector are defined events. A status-enable mask selects which pulses are recorded in a sticky status register. A separate signal-enable mask selects which recorded bits drive the single level-sensitive interrupt line.

Software uses a simple register port to reach four 32-bit registers. It clears recorded events by writing ones to the status register, normally writing back the value it has just read. It can also inject events through a force register, which always reads as zero. A typical set-up writes all ones to the status-enable register, so every event is recorded, and then chooses the events that interrupt with the signal-enable register.

Top module: `ring_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status, status-enable and signal-enable registers are cleared, and `irq` is low from the following cycle.
- R2: An event pulse on a defined bit whose status-enable bit is set makes the status bit 1 from the next cycle. The defined bits are: 12 IBI ready, 11 transfer done, 10 ring operation done, 9 transfer error, 7 stop inserted on mode change, 6 IBI ring full, 5 transfer abort. This gives a defined-bit mask of 0x1EE0.
- R3: An event pulse or force on a bit whose status-enable bit is clear does not change the status register.
- R4: A write to the status register at offset 0x10 clears every bit written as 1. Bits written as 0 keep their value.
- R5: If an enabled event and a clear of the same status bit occur in the same cycle, the bit is 1 afterwards.
- R6: A write to the force register at offset 0x1C sets each status bit that is written as 1 and is status-enabled. The force register always reads as 0.
- R7: `irq` is high exactly when some status bit and the matching signal-enable bit are both 1. Status bits whose signal-enable bit is 0 are still recorded.
- R8: The status-enable register is at offset 0x14 and the signal-enable register is at offset 0x18. Bits outside 0x1EE0 read as 0 and ignore writes. Any other address, including a misaligned one, reads 0 and ignores writes.
- R9: A read (`bus_sel`=1, `bus_wr`=0) returns `bus_rdata` with `bus_rvalid`=1 in the next cycle. The value is the register content before that cycle's updates. `bus_rvalid` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | Single-cycle event pulses from the ring engine, in status bit layout |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the ring register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `evt_pulse` and the bus inputs are known values at every sampled edge outside reset. They also assume that one access is presented per cycle and that a write and a read never share a cycle. The bench drives every input from a task at the falling edge, so each input holds a defined value over the whole sampling window. The random mix sends events on defined and undefined bits and reaches mapped, unmapped and misaligned offsets. It also makes clears and forces collide with events in the same cycle, which is the case the priority assertions depend on.

// File: rtl/ring_irq_pkg.sv
// Shared constants for the ring interrupt controller: register offsets,
// event bit positions and the mask of implemented bits.
package ring_irq_pkg;
    localparam int DATA_W = 32;

    // Byte offsets inside the ring register window
    localparam int OFF_STS = 'h10;
    localparam int OFF_SEN = 'h14;
    localparam int OFF_SIG = 'h18;
    localparam int OFF_FRC = 'h1C;

    // Event bit positions (shared with the ring engine)
    localparam int EV_IBI_RDY   = 12;
    localparam int EV_XFER_DONE = 11;
    localparam int EV_RING_OP   = 10;
    localparam int EV_XFER_ERR  = 9;
    localparam int EV_STOP_INS  = 7;
    localparam int EV_IBI_FULL  = 6;
    localparam int EV_XFER_ABRT = 5;

    localparam logic [DATA_W-1:0] EVT_MASK =
        (DATA_W'(1) << EV_IBI_RDY)  | (DATA_W'(1) << EV_XFER_DONE) |
        (DATA_W'(1) << EV_RING_OP)  | (DATA_W'(1) << EV_XFER_ERR)  |
        (DATA_W'(1) << EV_STOP_INS) | (DATA_W'(1) << EV_IBI_FULL)  |
        (DATA_W'(1) << EV_XFER_ABRT);

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STS,
        REG_SEN,
        REG_SIG,
        REG_FRC
    } reg_id_e;
endpackage

// File: rtl/ring_irq_decode.sv
// Address decoder. Maps an exact byte offset to one register and
// produces per-register write strobes plus a read strobe.
// Assumes one access per cycle; unknown offsets decode to REG_NONE.
module ring_irq_decode
    import ring_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           reg_id,
    output logic              wr_sts,
    output logic              wr_sen,
    output logic              wr_sig,
    output logic              wr_frc,
    output logic              rd_req
);
    // Offset to register identifier
    always_comb begin
        if (addr == ADDR_W'(OFF_STS))      reg_id = REG_STS;
        else if (addr == ADDR_W'(OFF_SEN)) reg_id = REG_SEN;
        else if (addr == ADDR_W'(OFF_SIG)) reg_id = REG_SIG;
        else if (addr == ADDR_W'(OFF_FRC)) reg_id = REG_FRC;
        else                               reg_id = REG_NONE;
    end

    // Strobes qualified by request and direction
    always_comb begin
        wr_sts = sel && wr && (reg_id == REG_STS);
        wr_sen = sel && wr && (reg_id == REG_SEN);
        wr_sig = sel && wr && (reg_id == REG_SIG);
        wr_frc = sel && wr && (reg_id == REG_FRC);
        rd_req = sel && !wr;
    end
endmodule

// File: rtl/ring_irq_mask_reg.sv
// Plain read/write mask register. Only bits set in MASK are stored;
// the others are constant zero. Synchronous active-low reset.
module ring_irq_mask_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic unused_bits;
    assign unused_bits = ^(wdata & ~MASK);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            // Load the bit on a write, clear on reset
            always_ff @(posedge clk) begin
                if (!rst_n)  q[i] <= 1'b0;
                else if (wr) q[i] <= wdata[i];
            end
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ring_irq_status.sv
// Sticky status register. A bit is set by an enabled event pulse or an
// enabled force write, cleared by a write-one-to-clear; set wins.
// Assumes event pulses are one cycle wide and known outside reset.
module ring_irq_status #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] sen,
    input  logic         clr_wr,
    input  logic         frc_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sts
);
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic         unused_bits;

    // Build set and clear requests for this cycle
    always_comb begin
        set_vec = sen & (evt | (frc_wr ? wdata : '0));
        clr_vec = clr_wr ? wdata : '0;
    end

    assign unused_bits = ^((set_vec | clr_vec) & ~MASK);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_impl
            // Set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)          sts[i] <= 1'b0;
                else if (set_vec[i]) sts[i] <= 1'b1;
                else if (clr_vec[i]) sts[i] <= 1'b0;
            end
        end else begin : g_zero
            assign sts[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ring_irq_ctrl.sv
// Per-ring interrupt register bank: status, status enable, signal enable
// and force, behind a simple register port with one-cycle read latency.
// Drives a level interrupt from status bits that are signal-enabled.
module ring_irq_ctrl
    import ring_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq
);
    reg_id_e           reg_id;
    logic              wr_sts, wr_sen, wr_sig, wr_frc, rd_req;
    logic [DATA_W-1:0] sts_q, sen_q, sig_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    ring_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .reg_id (reg_id),
        .wr_sts (wr_sts),
        .wr_sen (wr_sen),
        .wr_sig (wr_sig),
        .wr_frc (wr_frc),
        .rd_req (rd_req)
    );

    ring_irq_mask_reg #(.W(DATA_W), .MASK(EVT_MASK)) u_sen (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sen),
        .wdata (bus_wdata),
        .q     (sen_q)
    );

    ring_irq_mask_reg #(.W(DATA_W), .MASK(EVT_MASK)) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_sig),
        .wdata (bus_wdata),
        .q     (sig_q)
    );

    ring_irq_status #(.W(DATA_W), .MASK(EVT_MASK)) u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse),
        .sen    (sen_q),
        .clr_wr (wr_sts),
        .frc_wr (wr_frc),
        .wdata  (bus_wdata),
        .sts    (sts_q)
    );

    // Select read data; force and unmapped offsets read as zero
    always_comb begin
        unique case (reg_id)
            REG_STS: rd_mux = sts_q;
            REG_SEN: rd_mux = sen_q;
            REG_SIG: rd_mux = sig_q;
            default: rd_mux = '0;
        endcase
    end

    // Register read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_req;
            if (rd_req) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign irq        = |(sts_q & sig_q);
endmodule

// File: rtl/ring_irq_ctrl_chk.sv
// Assertion checker for ring_irq_ctrl, attached by bind.
// Assumes inputs are known at sampled edges outside reset.
module ring_irq_ctrl_chk
    import ring_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] evt_pulse,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              irq,
    input logic [DATA_W-1:0] sts_q,
    input logic [DATA_W-1:0] sen_q
);
    logic is_rd, is_clr, is_frc_rd;
    assign is_rd     = bus_sel && !bus_wr;
    assign is_clr    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STS));
    assign is_frc_rd = is_rd && (bus_addr == ADDR_W'(OFF_FRC));

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sts_q == '0 && !irq));

    a_r2_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_pulse & sen_q & EVT_MASK)) |=>
        ((sts_q & $past(evt_pulse & sen_q & EVT_MASK)) ==
         $past(evt_pulse & sen_q & EVT_MASK)));

    a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~sen_q & ~sts_q & EVT_MASK)) |=>
        ((sts_q & $past(~sen_q & ~sts_q)) == '0));

    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> ((sts_q & $past(sts_q & ~bus_wdata)) == $past(sts_q & ~bus_wdata)));

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (is_clr && |(evt_pulse & sen_q & bus_wdata & EVT_MASK)) |=>
        (|(sts_q & $past(evt_pulse & sen_q & bus_wdata & EVT_MASK))));

    a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_frc_rd |=> (bus_rdata == '0));

    a_r7_no_status_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q == '0) |-> !irq);

    a_r8_undef_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> ((bus_rdata & ~EVT_MASK) == '0));

    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> bus_rvalid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !bus_rvalid);
endmodule

bind ring_irq_ctrl ring_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_pulse  (evt_pulse),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .sts_q      (sts_q),
    .sen_q      (sen_q)
);

// File: tb/ring_irq_ctrl_bench.sv
module ring_irq_ctrl_bench;
    localparam logic [31:0] M = 32'h0000_1EE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_sts = '0, m_sen = '0, m_sig = '0;

    always #5 clk = ~clk;

    ring_irq_ctrl u_ring_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            8'h10:   return m_sts;
            8'h14:   return m_sen;
            8'h18:   return m_sig;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_sts(logic [31:0] ev, logic s, logic w,
                                              logic [7:0] a, logic [31:0] d);
        logic [31:0] setv, clrv;
        setv = m_sen & (ev | ((s && w && a == 8'h1C) ? d : 32'h0)) & M;
        clrv = (s && w && a == 8'h10) ? d : 32'h0;
        return ((m_sts & ~clrv) | setv) & M;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update model, check after the rising edge
    task automatic tick(logic [31:0] ev, logic s, logic w, logic [7:0] a,
                        logic [31:0] d, string req);
        logic [31:0] exp_rd, nsts;
        logic        is_rd;
        @(negedge clk);
        evt_pulse = ev; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        is_rd  = s && !w;
        exp_rd = model_read(a);
        nsts   = model_sts(ev, s, w, a, d);
        @(posedge clk);
        #1;
        m_sts = nsts;
        if (s && w && a == 8'h14) m_sen = d & M;
        if (s && w && a == 8'h18) m_sig = d & M;
        chk({req, " irq"}, {31'b0, irq}, {31'b0, |(m_sts & m_sig)});
        chk("R9 rvalid", {31'b0, bus_rvalid}, {31'b0, is_rd});
        if (is_rd) chk({req, " rdata"}, bus_rdata, exp_rd);
    endtask

    task automatic idle(string req);
        tick(32'h0, 1'b0, 1'b0, 8'h0, 32'h0, req);
    endtask

    task automatic rd(logic [7:0] a, string req);
        tick(32'h0, 1'b1, 1'b0, a, 32'h0, req);
    endtask

    task automatic wrr(logic [7:0] a, logic [31:0] d, string req);
        tick(32'h0, 1'b1, 1'b1, a, d, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1"); rd(8'h1C, "R1");
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        // R8 enable mask readback drops undefined bits
        wrr(8'h14, 32'hFFFF_FFFF, "R8");
        rd(8'h14, "R8");
        chk("R8 sen readback", bus_rdata, 32'h0000_1EE0);
        // R2 event recorded, R7 no irq without signal enable
        tick(32'h0000_0800, 1'b0, 1'b0, 8'h0, 32'h0, "R2");
        chk("R7 recorded but quiet", {31'b0, irq}, 32'h0);
        rd(8'h10, "R2");
        chk("R2 status bit 11", bus_rdata, 32'h0000_0800);
        // R7 signal enable raises irq
        wrr(8'h18, 32'h0000_0800, "R7");
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        // R4 write zero keeps, write one clears
        wrr(8'h10, 32'h0, "R4");
        chk("R4 zero keeps irq", {31'b0, irq}, 32'h1);
        wrr(8'h10, 32'h0000_0800, "R4");
        rd(8'h10, "R4");
        chk("R4 cleared", bus_rdata, 32'h0);
        // R5 event and clear collide on bit 9
        tick(32'h0000_0200, 1'b1, 1'b1, 8'h10, 32'h0000_0200, "R5");
        rd(8'h10, "R5");
        chk("R5 event wins", bus_rdata, 32'h0000_0200);
        wrr(8'h10, 32'hFFFF_FFFF, "R4");
        // R3 disabled events and forces ignored
        wrr(8'h14, 32'h0, "R3");
        tick(32'hFFFF_FFFF, 1'b0, 1'b0, 8'h0, 32'h0, "R3");
        wrr(8'h1C, 32'hFFFF_FFFF, "R3");
        rd(8'h10, "R3");
        chk("R3 status unchanged", bus_rdata, 32'h0);
        // R6 force sets enabled bit, force reads zero
        wrr(8'h14, 32'h0000_1EE0, "R6");
        wrr(8'h1C, 32'h0000_0040, "R6");
        rd(8'h10, "R6");
        chk("R6 forced bit 6", bus_rdata, 32'h0000_0040);
        rd(8'h1C, "R6");
        chk("R6 force reads zero", bus_rdata, 32'h0);
        // R8 unmapped and misaligned writes ignored
        wrr(8'h20, 32'hFFFF_FFFF, "R8");
        wrr(8'h11, 32'hFFFF_FFFF, "R8");
        rd(8'h10, "R8"); rd(8'h14, "R8"); rd(8'h18, "R8"); rd(8'h20, "R8");
        chk("R8 unmapped reads zero", bus_rdata, 32'h0);
        // R9 read returns pre-update value when event arrives in same cycle
        tick(32'h0000_1000, 1'b1, 1'b0, 8'h10, 32'h0, "R9");
        chk("R9 old value", bus_rdata, 32'h0000_0040);
        rd(8'h10, "R9");
        chk("R9 new value", bus_rdata, 32'h0000_1040);
        // Random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ev, d;
            logic [7:0]  a;
            logic        s, w;
            int          k;
            ev = ($urandom % 3 == 0) ? $urandom : 32'h0;
            s  = ($urandom % 2) == 1;
            w  = ($urandom % 2) == 1;
            k  = $urandom % 6;
            case (k)
                0: a = 8'h10;
                1: a = 8'h14;
                2: a = 8'h18;
                3: a = 8'h1C;
                4: a = 8'h10;
                default: a = 8'($urandom);
            endcase
            d = $urandom;
            tick(ev, s, w, a, d, "R2 R3 R4 R5 R6 R7 R8 random");
        end
        // R1 reset mid-run
        @(negedge clk);
        bus_sel = 1'b0; evt_pulse = '0; rst_n = 1'b0;
        @(posedge clk); #1;
        m_sts = '0; m_sen = '0; m_sig = '0;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h18, "R1");
        idle("R7");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule